// File: doc/BRIEF.md
# Code-Weighted Multichannel Sum-and-Dump Demodulator

This block recovers many small modulation components from one sampled detector signal. An external actuator applies one column of a Sylvester-ordered ±1 matrix per sync interval. The block moves its own column pointer in step with those intervals, waits for the actuator to settle, and then integrates the input sample once per channel. Each channel adds or subtracts the sample according to its matrix entry for the current column. At the end of the integration window every channel sum is arithmetically shifted down and presented on a wide result bus, together with a one-cycle strobe.

The sync level comes from an upstream detector that already qualifies pulses. The column pointer is the number of sync pulses modulo a programmable length. A programmable offset is added to it to absorb the delay between the actuator and the detector. A `summing` output shows when integration is taking place, so the sync timing can be tuned to frame it.

Top module: `hdm_demod`

## Requirements
- R1: While `rst_n` is low and after reset until the first dump, `result_valid` and `summing` are 0 and every channel of `result_flat` is 0.
- R2: The interval tick counter is held at 0 for every clock in which `sync_lvl` is high, and it counts up by one per clock once `sync_lvl` is low. The sample presented on the k-th clock edge after `sync_lvl` falls (k counting from 0) has tick k. With `settle_ticks` equal to 0, `summing` is therefore high on the very first low clock, however long sync was high.
- R3: `summing` is high exactly when `sync_lvl` is low and the tick k satisfies `settle_ticks` <= k < `settle_ticks` + `window_ticks` (`window_ticks` >= 1). The counter saturates, so there is only one window per interval.
- R4: Channel c (0 to N_CH-1) adds the sample on each summing edge when the parity of (c AND col) is even, and subtracts it when the parity is odd. Samples and sums are two's complement.
- R5: On the edge that takes the last sample of the window, every channel loads its sum arithmetically shifted right by `shift_amt` and truncated to 16 bits. Channel c occupies `result_flat[16c+15:16c]`. `result_valid` is high for the one following cycle only. The results hold until the next dump.
- R6: After a dump all channel sums restart from zero, so the next interval's results contain only its own samples.
- R7: If `sync_lvl` rises before the window ends, the partial sums are discarded. No strobe occurs for that interval.
- R8: A base index starts at 0 after reset and advances on every clock where `sync_lvl` is high and was low on the previous clock. The base becomes 0 when base+1 >= `code_len`, and base+1 otherwise. The active column is base + `code_offset`, minus `code_len` when that sum reaches `code_len`. `code_offset` < `code_len` is required.
- R9: With a `code_len` below N_CH (for example 5), the column sequence wraps at that length, and channel signs follow the wrapped column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_in | input | 16 | Signed detector sample, one per clock |
| sync_lvl | input | 1 | Qualified sync level; high between intervals |
| settle_ticks | input | 16 | Ticks ignored after sync falls |
| window_ticks | input | 16 | Integration length in ticks (>= 1) |
| shift_amt | input | 5 | Arithmetic right shift applied at dump |
| code_offset | input | 5 | Column offset added to the base index |
| code_len | input | 6 | Column wrap length, 1 to 32 |
| result_flat | output | 512 | 32 signed 16-bit channel results, channel 0 in the low bits |
| result_valid | output | 1 | One-cycle strobe after each dump |
| summing | output | 1 | High while samples are integrated |
| code_col | output | 5 | Active matrix column |

## Verification
Aborting a window part-way through is the hardest case to reach. Sync must rise after integration has started but before the last tick, and the following interval must then be shown to start from clean sums. The stimulus raises sync a few ticks into a long window. It then runs a full interval with an alternating-sign sample pattern, whose expected sums would be visibly offset by any residue. A second hard case is the column wrap at a short length entered from a long one. The base index may lie beyond the new length, and the bench models the base-reset rule to predict the column sequence across several intervals.

// File: rtl/hdm_pkg.sv
package hdm_pkg;
   // Sylvester matrix entry: negative when popcount(row & col) is odd
   function automatic logic entry_negative(input logic [31:0] row, input logic [31:0] col);
      return ^(row & col);
   endfunction
endpackage

// File: rtl/hdm_phase.sv
module hdm_phase #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_lvl,
   input  logic [CNT_W-1:0] settle_ticks,
   input  logic [CNT_W-1:0] window_ticks,
   output logic             summing,
   output logic             last_tick
);
   localparam int END_W = CNT_W + 1;

   logic [CNT_W-1:0] tick_q;
   logic [END_W-1:0] win_end;
   logic             in_window;

   always_ff @(posedge clk) begin
      if (!rst_n)              tick_q <= '0;
      else if (sync_lvl)       tick_q <= '0;
      else if (~&tick_q)       tick_q <= tick_q + 1'b1;
   end

   assign win_end   = {1'b0, settle_ticks} + {1'b0, window_ticks};
   assign in_window = (tick_q >= settle_ticks) && ({1'b0, tick_q} < win_end);
   assign summing   = !sync_lvl && in_window;
   assign last_tick = summing && ({1'b0, tick_q} == win_end - 1'b1);

   // R2: counter held at zero while sync is high
   assert_tick_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sync_lvl |=> (tick_q == '0));
   // R3: counting advances by one while sync stays low and not saturated
   assert_tick_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_lvl && ~&tick_q) |=> (tick_q == $past(tick_q) + 1'b1));
endmodule

// File: rtl/hdm_colptr.sv
module hdm_colptr #(
   parameter int N_CH  = 32,
   parameter int IDX_W = $clog2(N_CH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           sync_lvl,
   input  logic [IDX_W-1:0] code_offset,
   input  logic [IDX_W:0]   code_len,
   output logic [IDX_W-1:0] col
);
   logic             sync_q;
   logic [IDX_W-1:0] base_q;
   logic [IDX_W:0]   base_inc;
   logic [IDX_W:0]   col_sum;
   logic [IDX_W:0]   col_wrapped;
   logic             sync_rise;

   assign sync_rise = sync_lvl && !sync_q;
   assign base_inc  = {1'b0, base_q} + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= 1'b1;
         base_q <= '0;
      end else begin
         sync_q <= sync_lvl;
         if (sync_rise)
            base_q <= (base_inc >= code_len) ? '0 : base_inc[IDX_W-1:0];
      end
   end

   assign col_sum     = {1'b0, base_q} + {1'b0, code_offset};
   assign col_wrapped = (col_sum >= code_len) ? col_sum - code_len : col_sum;
   assign col         = col_wrapped[IDX_W-1:0];

   // R8: base index moves only on a sync rise
   assert_base_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_rise |=> $stable(base_q));
endmodule

// File: rtl/hdm_chan.sv
module hdm_chan #(
   parameter int SAMPLE_W = 16,
   parameter int ACC_W    = 32,
   parameter int OUT_W    = 16,
   parameter int SHIFT_W  = 5,
   parameter bit OUT_SAT  = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sync_lvl,
   input  logic                       summing,
   input  logic                       last_tick,
   input  logic                       negate,
   input  logic signed [SAMPLE_W-1:0] sample,
   input  logic [SHIFT_W-1:0]         shift_amt,
   output logic signed [OUT_W-1:0]    result
);
   logic signed [ACC_W-1:0] acc_q;
   logic signed [ACC_W-1:0] ext;
   logic signed [ACC_W-1:0] term;
   logic signed [ACC_W-1:0] total;
   logic signed [ACC_W-1:0] scaled;
   logic signed [OUT_W-1:0] shaped;

   assign ext    = {{(ACC_W-SAMPLE_W){sample[SAMPLE_W-1]}}, sample};
   assign term   = negate ? -ext : ext;
   assign total  = acc_q + term;
   assign scaled = total >>> shift_amt;

   generate
      if (OUT_SAT) begin : g_sat
         localparam logic signed [ACC_W-1:0] HI = ACC_W'((1 << (OUT_W-1)) - 1);
         localparam logic signed [ACC_W-1:0] LO = -ACC_W'(1 << (OUT_W-1));
         always_comb begin
            if (scaled > HI)      shaped = HI[OUT_W-1:0];
            else if (scaled < LO) shaped = LO[OUT_W-1:0];
            else                  shaped = scaled[OUT_W-1:0];
         end
      end else begin : g_trunc
         assign shaped = scaled[OUT_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q  <= '0;
         result <= '0;
      end else if (sync_lvl) begin
         acc_q <= '0;
      end else if (last_tick) begin
         acc_q  <= '0;
         result <= shaped;
      end else if (summing) begin
         acc_q <= total;
      end
   end

   // R6: sums restart from zero after a dump
   assert_acc_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      last_tick |=> (acc_q == '0));
   // R7: sync high discards the partial sum
   assert_abort_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sync_lvl |=> (acc_q == '0));
endmodule

// File: rtl/hdm_demod.sv
module hdm_demod #(
   parameter int N_CH     = 32,
   parameter int SAMPLE_W = 16,
   parameter int ACC_W    = 32,
   parameter int OUT_W    = 16,
   parameter int CNT_W    = 16,
   parameter bit OUT_SAT  = 1'b0,
   localparam int IDX_W   = $clog2(N_CH),
   localparam int SHIFT_W = $clog2(ACC_W)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [SAMPLE_W-1:0]     sample_in,
   input  logic                    sync_lvl,
   input  logic [CNT_W-1:0]        settle_ticks,
   input  logic [CNT_W-1:0]        window_ticks,
   input  logic [SHIFT_W-1:0]      shift_amt,
   input  logic [IDX_W-1:0]        code_offset,
   input  logic [IDX_W:0]          code_len,
   output logic [N_CH*OUT_W-1:0]   result_flat,
   output logic                    result_valid,
   output logic                    summing,
   output logic [IDX_W-1:0]        code_col
);
   import hdm_pkg::*;

   generate
      if ((N_CH & (N_CH - 1)) != 0 || N_CH < 2 || N_CH > 32)
         $error("N_CH must be a power of two from 2 to 32");
      if (ACC_W < SAMPLE_W + CNT_W)
         $error("ACC_W too narrow for the longest window");
      if (OUT_W > ACC_W)
         $error("OUT_W must not exceed ACC_W");
   endgenerate

   logic last_tick;

   hdm_phase #(.CNT_W(CNT_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .sync_lvl(sync_lvl),
      .settle_ticks(settle_ticks), .window_ticks(window_ticks),
      .summing(summing), .last_tick(last_tick)
   );

   hdm_colptr #(.N_CH(N_CH), .IDX_W(IDX_W)) u_col (
      .clk(clk), .rst_n(rst_n), .sync_lvl(sync_lvl),
      .code_offset(code_offset), .code_len(code_len), .col(code_col)
   );

   generate
      for (genvar c = 0; c < N_CH; c++) begin : g_ch
         logic neg;
         assign neg = entry_negative(32'(c), 32'(code_col));
         hdm_chan #(
            .SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .OUT_W(OUT_W),
            .SHIFT_W(SHIFT_W), .OUT_SAT(OUT_SAT)
         ) u_ch (
            .clk(clk), .rst_n(rst_n), .sync_lvl(sync_lvl),
            .summing(summing), .last_tick(last_tick), .negate(neg),
            .sample(sample_in), .shift_amt(shift_amt),
            .result(result_flat[c*OUT_W +: OUT_W])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) result_valid <= 1'b0;
      else        result_valid <= last_tick;
   end

   // R5: strobe lasts one cycle
   assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid);
   // R7: no dump on an edge where sync is high
   assert_no_dump_in_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sync_lvl |=> !result_valid);
   // R3: a dump always follows an integrating cycle
   assert_dump_after_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> $past(summing));
   // R3: summing never overlaps sync
   assert_summing_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      summing |-> !sync_lvl);
endmodule

// File: tb/hdm_demod_test.sv
module hdm_demod_test;
   localparam int N = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [15:0]       sample_in = '0;
   logic              sync_lvl = 1'b1;
   logic [15:0]       settle_ticks = 16'd3;
   logic [15:0]       window_ticks = 16'd8;
   logic [4:0]        shift_amt = '0;
   logic [4:0]        code_offset = '0;
   logic [5:0]        code_len = 6'd32;
   logic [N*16-1:0]   result_flat;
   logic              result_valid;
   logic              summing;
   logic [4:0]        code_col;

   int checks = 0;
   int fails  = 0;
   int base   = 0;
   bit done   = 1'b0;
   logic [N*16-1:0] expq[$];
   logic [N*16-1:0] last_exp = '0;

   always #5 clk = ~clk;

   hdm_demod uut (
      .clk(clk), .rst_n(rst_n), .sample_in(sample_in), .sync_lvl(sync_lvl),
      .settle_ticks(settle_ticks), .window_ticks(window_ticks),
      .shift_amt(shift_amt), .code_offset(code_offset), .code_len(code_len),
      .result_flat(result_flat), .result_valid(result_valid),
      .summing(summing), .code_col(code_col)
   );

   function automatic logic signed [15:0] pat(int mode, int k);
      case (mode)
         0: return 16'sd1000;
         1: return (k % 2 == 0) ? 16'sd700 : -16'sd300;
         2: return 16'((k * 37) % 200 - 100);
         default: return -16'sd32768;
      endcase
   endfunction

   task automatic check(bit ok, string req, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // driver: one sync interval; abort_at < 0 means full window
   task automatic run_interval(int hi, int st, int win, int sh, int off, int len,
                               int mode, int abort_at);
      logic signed [31:0] acc [N];
      int col;
      @(negedge clk);
      if (!sync_lvl) base = (base + 1 >= len) ? 0 : base + 1;
      sync_lvl = 1'b1;
      settle_ticks = 16'(st); window_ticks = 16'(win);
      shift_amt = 5'(sh); code_offset = 5'(off); code_len = 6'(len);
      repeat (hi - 1) @(negedge clk);
      col = base + off;
      if (col >= len) col -= len;
      #1 check(code_col == 5'(col), "R8/R9 column", code_col, col);
      for (int c = 0; c < N; c++) acc[c] = 0;
      for (int k = 0; k < st + win + 2; k++) begin
         bit exp_sum;
         @(negedge clk);
         if (k == abort_at) return;   // caller's next interval raises sync
         sync_lvl = 1'b0;
         sample_in = pat(mode, k);
         exp_sum = (k >= st) && (k < st + win);
         #1 check(summing == exp_sum, "R2/R3 summing", summing, exp_sum);
         if (exp_sum) begin
            for (int c = 0; c < N; c++)
               acc[c] = ^(c & col) ? acc[c] - 32'(pat(mode, k)) : acc[c] + 32'(pat(mode, k));
            if (k == st + win - 1) begin
               logic [N*16-1:0] e;
               for (int c = 0; c < N; c++) e[c*16 +: 16] = 16'(acc[c] >>> sh);
               expq.push_back(e);
            end
         end
      end
   endtask

   // monitor: compare each strobed result with the scoreboard head (R4, R5, R6)
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (rst_n && result_valid) begin
            if (expq.size() == 0) begin
               check(1'b0, "R7 unexpected strobe", 1, 0);
            end else begin
               logic [N*16-1:0] e;
               int bad;
               e = expq.pop_front();
               last_exp = e;
               bad = -1;
               for (int c = N - 1; c >= 0; c--)
                  if (result_flat[c*16 +: 16] !== e[c*16 +: 16]) bad = c;
               if (bad < 0) check(1'b1, "R4/R5 dump", 0, 0);
               else check(1'b0, $sformatf("R4/R5/R6 channel %0d", bad),
                          $signed(result_flat[bad*16 +: 16]), $signed(e[bad*16 +: 16]));
            end
         end
      end
   end

   initial begin
      #3_000_000;
      if (!done) begin
         check(1'b0, "watchdog", 0, 1);
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check(result_valid == 0, "R1 valid", result_valid, 0);
      check(summing == 0, "R1 summing", summing, 0);
      check(result_flat == '0, "R1 results", 1, 0);
      @(negedge clk) rst_n = 1'b1;
      #1 check(result_flat == '0, "R1 results after reset", 1, 0);
      // R4 all-positive column 0
      run_interval(3, 3, 8, 0, 0, 32, 0, -1);
      // R4 mixed signs, offset column, shift
      run_interval(4, 5, 10, 2, 3, 32, 2, -1);
      // R7 abort mid-window, then R6 fresh sums
      run_interval(3, 2, 20, 0, 0, 32, 0, 6);
      run_interval(3, 1, 9, 0, 1, 32, 1, -1);
      // R9 short wrap length
      for (int i = 0; i < 7; i++) run_interval(2, 1, 4, 0, 4, 5, (i % 3), -1);
      // R2 long sync high, zero settle; R5 full-scale with large shift
      run_interval(60, 0, 100, 13, 0, 32, 3, -1);
      // default-size interval
      run_interval(3, 2000, 10000, 13, 7, 32, 2, -1);
      // hold check: results stay after strobe (R5)
      @(negedge clk) sync_lvl = 1'b1;
      repeat (10) @(negedge clk);
      #1;
      check(result_flat == last_exp, "R5 results held", 0, 0);
      check(expq.size() == 0, "R5/R7 strobe count", expq.size(), 0);
      check(result_valid == 0, "R7 no strobe during sync", result_valid, 0);
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule